// File: doc/BRIEF.md
# Card Activation Power Sequencer

This block steps a smart card contact interface through its power-up and power-down orders. Its time base is a slow sequencer tick, one pulse every `TICK_DIV` fast-clock cycles, which gives a period T of about 25 µs at the default rate. Activation starts when the host raises `start`. At the next tick boundary the block turns on the DC-to-DC converter and latches the chosen card voltage. A fixed number of ticks later it starts the supply ramp. Some ticks after that it enables the I/O receive buffer. Last, it releases the card clock with reset still held low and emits a one-cycle strobe that starts the external answer-to-reset clock counting.

Dropping `start` at any point before or during the active session begins deactivation at the next tick boundary. At that boundary card reset is forced low. Half a tick later the card clock stops. One tick after the boundary the receive buffer is turned off and I/O is driven low. A configurable delay of about 5 µs, counted in fast-clock cycles, then starts the supply ramp-down. Four ticks after the boundary the converter is turned off and every card line is parked at ground. The sequence completes once the analog comparator reports that the supply has fallen below 0.4 V. Every output is a registered enable strobe, and the analog ramp itself lies outside the block.

Top module: `card_power_seq`

## Requirements
- R1: While idle, a high `start` seen on a tick edge raises `conv_en` and drops `lines_grounded` on that edge. The tick edges are the fast-clock edges numbered N, 2N, 3N, ..., where N is `TICK_DIV` and edges are counted from 1 after reset is released. So `conv_en` rises at the first tick edge at or after the edge where `start` is first sampled high.
- R2: `vcc_ramp_en` rises exactly `T_VCC` ticks after the `conv_en` rising edge.
- R3: `vcc_sel_5v` takes the value of `vsel_5v` on the edge where `conv_en` rises, and later changes of `vsel_5v` have no effect on it.
- R4: `io_rx_en` rises `T_IO` ticks after the `conv_en` rise. `card_clk_en` rises `T_IO + T_CLK_GAP` ticks after it. `clk_count_start` pulses high for exactly one cycle on that same edge, with `card_rst` low.
- R5: `card_rst` is low outside the active session. On the cycle after the clock release, and for as long as the session stays active, `card_rst` copies `rst_release` one edge later. It falls on the first tick edge at which `start` is sampled low (t10).
- R6: `card_clk_en` falls N/2 edges after t10. `io_rx_en` falls and `io_drive_low` rises N edges after t10.
- R7: `vcc_ramp_en` falls `DLY_CYC` edges after `io_drive_low` rises. `DLY_CYC` is `DLY_NS` nanoseconds of the `CLK_HZ` clock, rounded up, and is 5 at 1 MHz.
- R8: At t10 + `T_OFF`·N, `conv_en` and `io_drive_low` fall, `lines_grounded` rises, and every other card enable is low.
- R9: Once started, deactivation runs to the end whatever `start` does. `deact_done` pulses for one cycle on the first edge after the grounded state at which `vcc_below_min` is sampled high. Until that edge the block stays grounded and starts no new activation.
- R10: A `start` drop before the clock is released still follows the R5–R8 timing from its own t10. The clock, the receive buffer and `card_rst` never turn on.
- R11: After reset, `lines_grounded` is high and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, also the oscillator for the tick divider |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Session request: high activates, low deactivates |
| vsel_5v | input | 1 | Supply target choice: 1 selects 5 V, 0 selects 3 V |
| rst_release | input | 1 | Reset release request from the answer-to-reset logic |
| vcc_below_min | input | 1 | Comparator: card supply is below 0.4 V |
| conv_en | output | 1 | DC-to-DC converter enable |
| vcc_ramp_en | output | 1 | Card supply ramp enable (low means ramp down) |
| vcc_sel_5v | output | 1 | Latched supply target |
| io_rx_en | output | 1 | I/O receive buffer enable |
| io_drive_low | output | 1 | Drive card I/O low |
| card_clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset line level |
| clk_count_start | output | 1 | One-cycle strobe at clock release |
| lines_grounded | output | 1 | All card lines parked low-impedance to ground |
| deact_done | output | 1 | One-cycle strobe when deactivation completes |

## Verification
The bench sweeps the phase of the `start` edge over every position of the free-running tick divider, for both supply choices and for every deactivation phase. A design that restarted its divider on `start`, or that counted from the request rather than from the aligned boundary, would be off by up to one tick in some of those runs. The half-tick clock stop, the one-tick I/O step and the fast-cycle ramp-down delay are each timed against t10 separately, so that steps which are swapped or share the wrong counter show up as wrong edges. The runs also cover an early abort during the supply ramp, a re-raised `start` in the middle of deactivation, and a comparator that stays high too long. A design that restarted, lit the clock on abort or ended too early would show extra rising edges or a misplaced done strobe.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CONV,
    S_VCC,
    S_IO,
    S_ACTIVE,
    S_D_RST,
    S_D_CLKOFF,
    S_D_IOLOW,
    S_D_RAMPDN,
    S_D_OFF
  } seq_state_e;

  typedef struct packed {
    logic conv;
    logic ramp;
    logic io_rx;
    logic io_low;
    logic clk;
    logic grounded;
  } card_lines_t;

  localparam card_lines_t LINES_PARKED = '{conv: 1'b0, ramp: 1'b0, io_rx: 1'b0,
                                           io_low: 1'b0, clk: 1'b0, grounded: 1'b1};

endpackage

// File: rtl/card_seq_tick.sv
// Free-running divider: one tick per DIV fast cycles, plus a mid-period pulse.
module card_seq_tick #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic half
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (cnt_q == W'(DIV - 1)) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == W'(DIV - 1));
  assign half = (cnt_q == W'(DIV / 2 - 1));
endmodule

// File: rtl/card_seq_tcount.sv
// Counts ticks since the last anchor point, saturating at MAXC.
module card_seq_tcount #(
  parameter int unsigned MAXC = 76,
  localparam int unsigned W = $clog2(MAXC + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)                         count <= '0;
    else if (tick && (count != W'(MAXC)))   count <= count + 1'b1;
  end
endmodule

// File: rtl/card_seq_delay.sv
// Fast-cycle one-shot: expires CYC cycles after load while active.
module card_seq_delay #(
  parameter int unsigned CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic active,
  output logic expired
);
  localparam int unsigned W = (CYC > 1) ? $clog2(CYC) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                           cnt_q <= '0;
    else if (load)                     cnt_q <= W'(CYC - 1);
    else if (active && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = active && (cnt_q == '0);
endmodule

// File: rtl/card_seq_fsm.sv
// Step sequencer with event-driven output registers.
module card_seq_fsm
  import card_seq_pkg::*;
#(
  parameter int unsigned T_VCC     = 32,
  parameter int unsigned T_IO      = 72,
  parameter int unsigned T_CLK_GAP = 4,
  parameter int unsigned T_OFF     = 4,
  parameter int unsigned TCW       = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           half,
  input  logic [TCW-1:0] tcnt,
  input  logic           dly_expired,
  input  logic           start,
  input  logic           vsel_5v,
  input  logic           rst_release,
  input  logic           vcc_below_min,
  output logic           tcnt_clr,
  output logic           dly_load,
  output logic           dly_active,
  output card_lines_t    lines,
  output logic           vsel_q,
  output logic           card_rst,
  output logic           cnt_start,
  output logic           done
);
  seq_state_e state_q, state_d;
  logic       abort;
  logic       off_due;

  assign abort   = tick && !start;
  assign off_due = tick && (tcnt == TCW'(T_OFF - 1));

  always_comb begin
    state_d  = state_q;
    tcnt_clr = 1'b0;
    dly_load = 1'b0;
    unique case (state_q)
      S_IDLE: if (tick && start) begin
        state_d  = S_CONV;
        tcnt_clr = 1'b1;
      end
      S_CONV: if (abort) begin
        state_d  = S_D_RST;
        tcnt_clr = 1'b1;
      end else if (tick && tcnt == TCW'(T_VCC - 1)) begin
        state_d = S_VCC;
      end
      S_VCC: if (abort) begin
        state_d  = S_D_RST;
        tcnt_clr = 1'b1;
      end else if (tick && tcnt == TCW'(T_IO - 1)) begin
        state_d = S_IO;
      end
      S_IO: if (abort) begin
        state_d  = S_D_RST;
        tcnt_clr = 1'b1;
      end else if (tick && tcnt == TCW'(T_IO + T_CLK_GAP - 1)) begin
        state_d = S_ACTIVE;
      end
      S_ACTIVE: if (abort) begin
        state_d  = S_D_RST;
        tcnt_clr = 1'b1;
      end
      S_D_RST:    if (half) state_d = S_D_CLKOFF;
      S_D_CLKOFF: if (tick) begin
        state_d  = S_D_IOLOW;
        dly_load = 1'b1;
      end
      S_D_IOLOW: begin
        if (off_due)          state_d = S_D_OFF;
        else if (dly_expired) state_d = S_D_RAMPDN;
      end
      S_D_RAMPDN: if (off_due) state_d = S_D_OFF;
      S_D_OFF:    if (vcc_below_min) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  assign dly_active = (state_q == S_D_IOLOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      lines     <= LINES_PARKED;
      vsel_q    <= 1'b0;
      card_rst  <= 1'b0;
      cnt_start <= 1'b0;
      done      <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_start <= 1'b0;
      done      <= 1'b0;
      card_rst  <= (state_q == S_ACTIVE) && (state_d == S_ACTIVE) && rst_release;
      if (state_d != state_q) begin
        unique case (state_d)
          S_CONV: begin
            lines.conv     <= 1'b1;
            lines.grounded <= 1'b0;
            vsel_q         <= vsel_5v;
          end
          S_VCC:      lines.ramp  <= 1'b1;
          S_IO:       lines.io_rx <= 1'b1;
          S_ACTIVE: begin
            lines.clk <= 1'b1;
            cnt_start <= 1'b1;
          end
          S_D_RST:    ;
          S_D_CLKOFF: lines.clk <= 1'b0;
          S_D_IOLOW: begin
            lines.io_rx  <= 1'b0;
            lines.io_low <= 1'b1;
          end
          S_D_RAMPDN: lines.ramp <= 1'b0;
          S_D_OFF:    lines <= LINES_PARKED;
          S_IDLE:     done <= 1'b1;
          default:    lines <= LINES_PARKED;
        endcase
      end
    end
  end
endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import card_seq_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 64,
  parameter int unsigned T_VCC     = 32,
  parameter int unsigned T_IO      = 72,
  parameter int unsigned T_CLK_GAP = 4,
  parameter int unsigned T_OFF     = 4,
  parameter int unsigned CLK_HZ    = 2_560_000,
  parameter int unsigned DLY_NS    = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic vsel_5v,
  input  logic rst_release,
  input  logic vcc_below_min,
  output logic conv_en,
  output logic vcc_ramp_en,
  output logic vcc_sel_5v,
  output logic io_rx_en,
  output logic io_drive_low,
  output logic card_clk_en,
  output logic card_rst,
  output logic clk_count_start,
  output logic lines_grounded,
  output logic deact_done
);
  localparam int unsigned T_MAX   = T_IO + T_CLK_GAP;
  localparam int unsigned TCW     = $clog2(T_MAX + 1);
  localparam int unsigned DLY_RAW = ((CLK_HZ / 1000) * DLY_NS + 999_999) / 1_000_000;
  localparam int unsigned DLY_CYC = (DLY_RAW < 1) ? 1 : DLY_RAW;

  logic           seq_tick, seq_half;
  logic [TCW-1:0] tcnt;
  logic           tcnt_clr, dly_load, dly_active, dly_expired;
  card_lines_t    lines;

  card_seq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(seq_tick), .half(seq_half)
  );

  card_seq_tcount #(.MAXC(T_MAX)) u_tcnt (
    .clk(clk), .rst(rst), .clr(tcnt_clr), .tick(seq_tick), .count(tcnt)
  );

  card_seq_delay #(.CYC(DLY_CYC)) u_dly (
    .clk(clk), .rst(rst), .load(dly_load), .active(dly_active), .expired(dly_expired)
  );

  card_seq_fsm #(
    .T_VCC(T_VCC), .T_IO(T_IO), .T_CLK_GAP(T_CLK_GAP), .T_OFF(T_OFF), .TCW(TCW)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick(seq_tick), .half(seq_half), .tcnt(tcnt),
    .dly_expired(dly_expired), .start(start), .vsel_5v(vsel_5v),
    .rst_release(rst_release), .vcc_below_min(vcc_below_min),
    .tcnt_clr(tcnt_clr), .dly_load(dly_load), .dly_active(dly_active),
    .lines(lines), .vsel_q(vcc_sel_5v), .card_rst(card_rst),
    .cnt_start(clk_count_start), .done(deact_done)
  );

  assign conv_en        = lines.conv;
  assign vcc_ramp_en    = lines.ramp;
  assign io_rx_en       = lines.io_rx;
  assign io_drive_low   = lines.io_low;
  assign card_clk_en    = lines.clk;
  assign lines_grounded = lines.grounded;
endmodule

// File: rtl/card_power_seq_chk.sv
module card_power_seq_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic conv_en,
  input logic vcc_ramp_en,
  input logic io_rx_en,
  input logic io_drive_low,
  input logic card_clk_en,
  input logic card_rst,
  input logic clk_count_start,
  input logic lines_grounded,
  input logic deact_done
);
  p_conv_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_en) |-> $past(tick));
  p_ramp_needs_conv_r2: assert property (@(posedge clk) disable iff (rst)
    vcc_ramp_en |-> conv_en);
  p_clk_needs_io_r4: assert property (@(posedge clk) disable iff (rst)
    card_clk_en |-> io_rx_en);
  p_count_start_rst_low_r4: assert property (@(posedge clk) disable iff (rst)
    clk_count_start |-> (card_clk_en && !card_rst));
  p_rst_needs_clk_r5: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> card_clk_en);
  p_io_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    io_drive_low |-> !io_rx_en);
  p_grounded_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    lines_grounded |-> !(conv_en || vcc_ramp_en || io_rx_en || io_drive_low || card_clk_en));
  p_off_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_en) |-> $past(tick));
  p_done_grounded_r9: assert property (@(posedge clk) disable iff (rst)
    deact_done |-> (lines_grounded && !conv_en));
endmodule

bind card_power_seq card_power_seq_chk u_chk (
  .clk(clk), .rst(rst), .tick(seq_tick), .conv_en(conv_en), .vcc_ramp_en(vcc_ramp_en),
  .io_rx_en(io_rx_en), .io_drive_low(io_drive_low), .card_clk_en(card_clk_en),
  .card_rst(card_rst), .clk_count_start(clk_count_start),
  .lines_grounded(lines_grounded), .deact_done(deact_done)
);

// File: tb/card_power_seq_tb.sv
`timescale 1ns/1ps
module card_power_seq_tb_top;
  localparam int PER   = 10;
  localparam int N     = 8;
  localparam int TV    = 32;
  localparam int TI    = 72;
  localparam int TG    = 4;
  localparam int TO    = 4;
  localparam int DLY   = 5;
  localparam int NSIG  = 9;
  localparam int I_CONV = 0, I_RAMP = 1, I_IORX = 2, I_IOLOW = 3, I_CLK = 4,
                 I_RST = 5, I_CNT = 6, I_GND = 7, I_DONE = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, vsel_5v = 1'b0, rst_release = 1'b0, vcc_below_min = 1'b0;
  logic conv_en, vcc_ramp_en, vcc_sel_5v, io_rx_en, io_drive_low, card_clk_en;
  logic card_rst, clk_count_start, lines_grounded, deact_done;

  int ecnt = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int rise_e[NSIG], fall_e[NSIG], rise_n[NSIG];
  logic [NSIG-1:0] cur, prv;

  card_power_seq #(.TICK_DIV(N), .CLK_HZ(1_000_000)) dut_i (
    .clk(clk), .rst(rst), .start(start), .vsel_5v(vsel_5v), .rst_release(rst_release),
    .vcc_below_min(vcc_below_min), .conv_en(conv_en), .vcc_ramp_en(vcc_ramp_en),
    .vcc_sel_5v(vcc_sel_5v), .io_rx_en(io_rx_en), .io_drive_low(io_drive_low),
    .card_clk_en(card_clk_en), .card_rst(card_rst), .clk_count_start(clk_count_start),
    .lines_grounded(lines_grounded), .deact_done(deact_done)
  );

  always #(PER/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  assign cur = {deact_done, lines_grounded, clk_count_start, card_rst, card_clk_en,
                io_drive_low, io_rx_en, vcc_ramp_en, conv_en};

  initial prv = '0;
  always @(negedge clk) begin
    for (int i = 0; i < NSIG; i++) begin
      if (cur[i] && !prv[i]) begin rise_e[i] = ecnt; rise_n[i] = rise_n[i] + 1; end
      if (!cur[i] && prv[i]) fall_e[i] = ecnt;
    end
    prv = cur;
  end

  task automatic clear_ev();
    for (int i = 0; i < NSIG; i++) begin rise_e[i] = -1; fall_e[i] = -1; rise_n[i] = 0; end
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #(PER/4);
  endtask

  task automatic wait_to(int e);
    while (ecnt < e) step();
  endtask

  task automatic align(int ph);
    step();
    while (((ecnt + 1) % N) != ph) step();
  endtask

  function automatic int next_tick(int e);
    return ((e + N - 1) / N) * N;
  endfunction

  // Activation with start phase p; returns t1
  task automatic activate(int p, bit v, output int t1);
    int s;
    clear_ev();
    vcc_below_min = 1'b0;
    rst_release   = 1'b1;
    align(p);
    start = 1'b1; vsel_5v = v;
    s  = ecnt + 1;
    t1 = next_tick(s);
    wait_to(t1 + 2);
    vsel_5v = ~v;
    chk("R1", "conv_en rise edge", rise_e[I_CONV], t1);
    chk("R1", "grounded fall edge", fall_e[I_GND], t1);
  endtask

  task automatic finish_off(int t10);
    int v;
    wait_to(t10 + TO*N + 2*N);
    chk("R9", "no done before comparator", rise_n[I_DONE], 0);
    chk("R9", "still grounded", int'(lines_grounded), 1);
    start = 1'b0;
    vcc_below_min = 1'b1;
    v = ecnt + 1;
    wait_to(v + 2*N);
    chk("R9", "done edge", rise_e[I_DONE], v);
    chk("R9", "done pulse count", rise_n[I_DONE], 1);
  endtask

  task automatic full_run(int p, bit v, int q, bit reraise);
    int t1, d, t10, ca;
    activate(p, v, t1);
    ca = t1 + (TI + TG)*N;
    wait_to(ca + 3);
    chk("R2", "ramp rise edge", rise_e[I_RAMP], t1 + TV*N);
    chk("R3", "latched supply select", int'(vcc_sel_5v), int'(v));
    chk("R4", "io_rx rise edge", rise_e[I_IORX], t1 + TI*N);
    chk("R4", "clk rise edge", rise_e[I_CLK], ca);
    chk("R4", "count strobe edge", rise_e[I_CNT], ca);
    chk("R4", "count strobe pulses", rise_n[I_CNT], 1);
    chk("R5", "reset rise after release", rise_e[I_RST], ca + 1);
    rst_release = 1'b0;
    d = ecnt + 1;
    wait_to(d + 1);
    chk("R5", "reset follows release", fall_e[I_RST], d);
    rst_release = 1'b1;
    wait_to(d + 3);
    align(q);
    start = 1'b0;
    d = ecnt + 1;
    t10 = next_tick(d);
    if (reraise) begin
      wait_to(t10 + N + 1);
      start = 1'b1;
    end
    wait_to(t10 + TO*N + 2);
    chk("R5", "reset fall at t10", fall_e[I_RST], t10);
    chk("R6", "clk stop edge", fall_e[I_CLK], t10 + N/2);
    chk("R6", "io_rx fall edge", fall_e[I_IORX], t10 + N);
    chk("R6", "io low rise edge", rise_e[I_IOLOW], t10 + N);
    chk("R7", "ramp down edge", fall_e[I_RAMP], t10 + N + DLY);
    chk("R8", "conv off edge", fall_e[I_CONV], t10 + TO*N);
    chk("R8", "grounded edge", rise_e[I_GND], t10 + TO*N);
    chk("R8", "io low release edge", fall_e[I_IOLOW], t10 + TO*N);
    chk("R9", "no restart during deactivation", rise_n[I_CONV], 1);
    finish_off(t10);
  endtask

  task automatic abort_run(int p, int q);
    int t1, d, t10;
    activate(p, 1'b0, t1);
    wait_to(t1 + (TV + 4)*N);
    align(q);
    start = 1'b0;
    d = ecnt + 1;
    t10 = next_tick(d);
    wait_to(t10 + TO*N + 2);
    chk("R10", "io low edge", rise_e[I_IOLOW], t10 + N);
    chk("R10", "ramp down edge", fall_e[I_RAMP], t10 + N + DLY);
    chk("R10", "conv off edge", fall_e[I_CONV], t10 + TO*N);
    chk("R10", "clk never on", rise_n[I_CLK], 0);
    chk("R10", "io_rx never on", rise_n[I_IORX], 0);
    chk("R10", "reset never high", rise_n[I_RST], 0);
    finish_off(t10);
  endtask

  initial begin
    clear_ev();
    repeat (4) @(posedge clk);
    #(PER/4);
    chk("R11", "grounded in reset", int'(lines_grounded), 1);
    chk("R11", "other outputs in reset",
        int'({conv_en, vcc_ramp_en, vcc_sel_5v, io_rx_en, io_drive_low, card_clk_en,
              card_rst, clk_count_start, deact_done}), 0);
    rst = 1'b0;
    for (int p = 0; p < N; p++) begin
      full_run(p, p[0], (p * 3 + 1) % N, p[1]);
      full_run(p, ~p[0], (p * 5) % N, ~p[1]);
    end
    abort_run(3, 6);
    abort_run(0, 5);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule